// File: doc/BRIEF.md
# Read Request ID Tracker

This block sits on the requesting side of a read channel between a cache and a memory controller. It watches each read request as it is issued. A request carries a small request ID and an address. The block keeps one in-flight bit per ID and checks the handshake rules: each request needs its own acknowledge, IDs are unique while in flight, and the number in flight is limited. A read returns as a fixed number of data-valid beats, and each beat carries the ID and a chunk index. One beat counter for the channel counts these beats. The ID is retired on the final beat of its return.

Each beat's data and ECC arrive a fixed number of cycles after that beat's valid. A delay line re-times the valid, ID and chunk so they line up with the data. The data and ECC pass through in that cycle and read as zero in all other cycles. The block does not store data and does not check ECC. Four sticky error flags report protocol faults: an unexpected return, an ID reused, an issue while full, and a missing acknowledge. The block also reports the lowest free ID and a full flag, so the requester can pick its next tag.

Top module: `rd_id_tracker`

## Requirements
- R1: After reset, busy_o is all zero, every error flag is 0, full_o is 0, free_id_o is 0 and beat_vld_o is 0.
- R2: An accepted request whose ID is free sets bit busy_o[req_id_i] from the next cycle. free_id_o always shows the lowest ID whose busy bit is 0. full_o is 1 exactly when all IDs (8 by default) are busy.
- R3: A request is accepted only if no earlier request still waits for its acknowledge, or if ack_i is high in the same cycle. A request that is not accepted sets err_noack_o and does not change busy_o.
- R4: An accepted request whose ID is already busy, while full_o is 0, sets err_reuse_o and leaves busy_o unchanged.
- R5: An accepted request while full_o is 1 sets err_over_o and does not set err_reuse_o.
- R6: Each ret_vld_i beat advances a channel beat counter modulo BEATS (default 4). On the beat where the counter equals BEATS-1, busy_o[ret_id_i] clears. Earlier beats leave busy_o unchanged.
- R7: A return beat whose ID is not busy sets err_unexp_o.
- R8: beat_vld_o is high exactly DATA_LAT (default 3) cycles after a ret_vld_i cycle. In that cycle beat_id_o and beat_chunk_o carry that beat's ID and chunk, and beat_data_o and beat_ecc_o carry rd_data_i and rd_ecc_i. When beat_vld_o is low, all four of these outputs are zero.
- R9: Every error flag stays set until reset.
- R10: req_id_i and req_addr_i are known whenever req_i is high. ret_id_i and ret_chunk_i are known whenever ret_vld_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request issued this cycle |
| req_id_i | input | ID_W | Request ID |
| req_addr_i | input | ADDR_W | Request address |
| ack_i | input | 1 | Read acknowledge |
| ret_vld_i | input | 1 | Return beat valid |
| ret_id_i | input | ID_W | Return beat ID |
| ret_chunk_i | input | CHUNK_W | Return beat chunk index |
| rd_data_i | input | DATA_W | Read data, DATA_LAT cycles after its valid |
| rd_ecc_i | input | ECC_W | Read ECC, aligned with rd_data_i |
| beat_vld_o | output | 1 | Delayed beat valid, aligned with data |
| beat_id_o | output | ID_W | Delayed beat ID |
| beat_chunk_o | output | CHUNK_W | Delayed beat chunk |
| beat_data_o | output | DATA_W | Gated read data |
| beat_ecc_o | output | ECC_W | Gated read ECC |
| busy_o | output | NUM_IDS | In-flight bit per ID |
| free_id_o | output | ID_W | Lowest free ID |
| full_o | output | 1 | All IDs in flight |
| err_unexp_o | output | 1 | Sticky: return of an ID not in flight |
| err_reuse_o | output | 1 | Sticky: ID issued while in flight |
| err_over_o | output | 1 | Sticky: issue while full |
| err_noack_o | output | 1 | Sticky: issue before previous acknowledge |

## Verification
The bench builds the tracker with its default parameters: 3-bit IDs, 4 beats per return and a 3-cycle data latency. With these values, filling all eight IDs takes only a few dozen cycles, so the full flag and the overflow error are quick to reach. A single four-beat return shows both sides of the retire point: the three beats that leave the ID busy and the beat that clears it. With the 3-cycle latency, the bench can check that the data strobe is absent in the cycle before its slot, present in its slot and gone in the cycle after.

// File: rtl/rd_id_pkg.sv
package rd_id_pkg;
  typedef struct packed {
    logic unexp;
    logic reuse;
    logic over;
    logic noack;
  } rd_err_t;
endpackage

// File: rtl/rd_id_table.sv
module rd_id_table #(
  parameter int NUM_IDS = 8,
  parameter int ID_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic [ID_W-1:0]    set_id_i,
  input  logic               clr_i,
  input  logic [ID_W-1:0]    clr_id_i,
  output logic [NUM_IDS-1:0] busy_o
);
  logic [NUM_IDS-1:0] busy_q;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    busy_q[i] <= 1'b0;
      else if (set_i && set_id_i == ID_W'(i))         busy_q[i] <= 1'b1; // set wins
      else if (clr_i && clr_id_i == ID_W'(i))         busy_q[i] <= 1'b0;
    end
  end

  assign busy_o = busy_q;

  // R2
  set_marks_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> busy_o[$past(set_id_i)]);
  // R6
  clr_frees_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(set_i && set_id_i == clr_id_i)) |=> !busy_o[$past(clr_id_i)]);
endmodule

// File: rtl/rd_free_find.sv
module rd_free_find #(
  parameter int NUM_IDS = 8,
  parameter int ID_W    = 3
) (
  input  logic [NUM_IDS-1:0] busy_i,
  output logic [ID_W-1:0]    free_id_o,
  output logic               full_o
);
  always_comb begin
    free_id_o = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (!busy_i[i]) free_id_o = ID_W'(i);
    end
  end

  assign full_o = &busy_i;
endmodule

// File: rtl/rd_beat_delay.sv
module rd_beat_delay #(
  parameter int LAT = 3,
  parameter int W   = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] tag_i,
  output logic         vld_o,
  output logic [W-1:0] tag_o
);
  logic [LAT-1:0] vld_q;
  logic [W-1:0]   tag_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    logic         vin;
    logic [W-1:0] tin;
    if (s == 0) begin : g_head
      assign vin = vld_i;
      assign tin = tag_i;
    end else begin : g_body
      assign vin = vld_q[s-1];
      assign tin = tag_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        tag_q[s] <= '0;
      end else begin
        vld_q[s] <= vin;
        tag_q[s] <= vin ? tin : '0;
      end
    end
    if (s < LAT - 1) begin : g_chk
      // R8
      stage_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_q[s] |=> vld_q[s+1]);
    end
  end

  assign vld_o = vld_q[LAT-1];
  assign tag_o = tag_q[LAT-1];
endmodule

// File: rtl/rd_id_tracker.sv
module rd_id_tracker
  import rd_id_pkg::*;
#(
  parameter int ID_W     = 3,
  parameter int ADDR_W   = 40,
  parameter int BEATS    = 4,
  parameter int DATA_W   = 128,
  parameter int ECC_W    = 28,
  parameter int DATA_LAT = 3,
  localparam int NUM_IDS = 1 << ID_W,
  localparam int CHUNK_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [ID_W-1:0]    req_id_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               ack_i,
  input  logic               ret_vld_i,
  input  logic [ID_W-1:0]    ret_id_i,
  input  logic [CHUNK_W-1:0] ret_chunk_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  input  logic [ECC_W-1:0]   rd_ecc_i,
  output logic               beat_vld_o,
  output logic [ID_W-1:0]    beat_id_o,
  output logic [CHUNK_W-1:0] beat_chunk_o,
  output logic [DATA_W-1:0]  beat_data_o,
  output logic [ECC_W-1:0]   beat_ecc_o,
  output logic [NUM_IDS-1:0] busy_o,
  output logic [ID_W-1:0]    free_id_o,
  output logic               full_o,
  output logic               err_unexp_o,
  output logic               err_reuse_o,
  output logic               err_over_o,
  output logic               err_noack_o
);
  localparam int TAG_W = ID_W + CHUNK_W;

  logic               ack_wait_q;
  logic [CHUNK_W-1:0] beat_cnt_q;
  rd_err_t            err_q, err_d;
  logic               req_ok, id_set, last_beat;
  logic [TAG_W-1:0]   tag_dly;

  // a same-cycle ack closes the previous request
  assign req_ok    = req_i && !(ack_wait_q && !ack_i);
  assign id_set    = req_ok && !full_o && !busy_o[req_id_i];
  assign last_beat = ret_vld_i && (beat_cnt_q == CHUNK_W'(BEATS - 1));

  rd_id_table #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) i_table (
    .clk_i, .rst_ni,
    .set_i(id_set), .set_id_i(req_id_i),
    .clr_i(last_beat), .clr_id_i(ret_id_i),
    .busy_o
  );

  rd_free_find #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) i_free (
    .busy_i(busy_o), .free_id_o, .full_o
  );

  rd_beat_delay #(.LAT(DATA_LAT), .W(TAG_W)) i_dly (
    .clk_i, .rst_ni,
    .vld_i(ret_vld_i), .tag_i({ret_id_i, ret_chunk_i}),
    .vld_o(beat_vld_o), .tag_o(tag_dly)
  );

  assign {beat_id_o, beat_chunk_o} = tag_dly;
  assign beat_data_o = beat_vld_o ? rd_data_i : '0;
  assign beat_ecc_o  = beat_vld_o ? rd_ecc_i  : '0;

  always_comb begin
    err_d       = err_q;
    err_d.noack = err_q.noack | (req_i && !req_ok);
    err_d.over  = err_q.over  | (req_ok && full_o);
    err_d.reuse = err_q.reuse | (req_ok && !full_o && busy_o[req_id_i]);
    err_d.unexp = err_q.unexp | (ret_vld_i && !busy_o[ret_id_i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_wait_q <= 1'b0;
      beat_cnt_q <= '0;
      err_q      <= '0;
    end else begin
      err_q <= err_d;
      if (req_ok)     ack_wait_q <= 1'b1;
      else if (ack_i) ack_wait_q <= 1'b0;
      if (ret_vld_i)  beat_cnt_q <= last_beat ? '0 : beat_cnt_q + 1'b1;
    end
  end

  assign err_unexp_o = err_q.unexp;
  assign err_reuse_o = err_q.reuse;
  assign err_over_o  = err_q.over;
  assign err_noack_o = err_q.noack;

  // R3
  noack_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ack_wait_q && !ack_i) |=> err_noack_o);
  // R5
  over_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(ack_wait_q && !ack_i) && full_o) |=> err_over_o);
  // R7
  unexp_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_vld_i && !busy_o[ret_id_i]) |=> err_unexp_o);
  // R9
  sticky_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_unexp_o || err_reuse_o || err_over_o || err_noack_o) |=>
      ($past(err_unexp_o) <= err_unexp_o) && ($past(err_reuse_o) <= err_reuse_o) &&
      ($past(err_over_o) <= err_over_o) && ($past(err_noack_o) <= err_noack_o));
  // R2
  free_is_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o |-> !busy_o[free_id_o]);
  // R10
  req_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !$isunknown({req_id_i, req_addr_i}));
  // R10
  ret_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_vld_i |-> !$isunknown({ret_id_i, ret_chunk_i}));
endmodule

// File: tb/test_rd_id_tracker.sv
`timescale 1ns/1ps
module test_rd_id_tracker;
  localparam int ID_W = 3, ADDR_W = 40, BEATS = 4, DATA_W = 128, ECC_W = 28, LAT = 3;
  localparam int NID = 1 << ID_W;
  localparam int CW  = 2;

  logic clk = 0, rst_n = 0;
  logic req = 0, ack = 0, rvld = 0;
  logic [ID_W-1:0] req_id = '0, rid = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [CW-1:0] rchunk = '0;
  logic [DATA_W-1:0] rdata = '0;
  logic [ECC_W-1:0] recc = '0;
  logic bvld, full, e_unexp, e_reuse, e_over, e_noack;
  logic [ID_W-1:0] bid, free_id;
  logic [CW-1:0] bchunk;
  logic [DATA_W-1:0] bdata;
  logic [ECC_W-1:0] becc;
  logic [NID-1:0] busy;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rd_id_tracker #(.ID_W(ID_W), .ADDR_W(ADDR_W), .BEATS(BEATS), .DATA_W(DATA_W),
                  .ECC_W(ECC_W), .DATA_LAT(LAT)) i_rd_id_tracker (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_id_i(req_id), .req_addr_i(addr),
    .ack_i(ack), .ret_vld_i(rvld), .ret_id_i(rid), .ret_chunk_i(rchunk),
    .rd_data_i(rdata), .rd_ecc_i(recc), .beat_vld_o(bvld), .beat_id_o(bid),
    .beat_chunk_o(bchunk), .beat_data_o(bdata), .beat_ecc_o(becc), .busy_o(busy),
    .free_id_o(free_id), .full_o(full), .err_unexp_o(e_unexp), .err_reuse_o(e_reuse),
    .err_over_o(e_over), .err_noack_o(e_noack));

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic errs(string tag, logic [3:0] exp);
    chk(tag, {e_unexp, e_reuse, e_over, e_noack}, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req = 0; ack = 0; rvld = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic issue(int id);
    req = 1; req_id = ID_W'(id); addr = ADDR_W'(64'h40 * id + 64'h1000);
    @(negedge clk);
    req = 0; ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic beat(int id, int ch);
    rvld = 1; rid = ID_W'(id); rchunk = CW'(ch);
    @(negedge clk);
    rvld = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busy", busy, 0);
    errs("R1 errs", 4'b0000);
    chk("R1 free/full", {free_id, full}, 4'b0000);
    chk("R1 beat_vld", bvld, 0);
  endtask

  task automatic t_issue();
    do_reset();
    issue(0); issue(1); issue(3);
    chk("R2 busy", busy, 8'b0000_1011);
    chk("R2 free lowest", free_id, 2);
    chk("R10 known req ok", {e_noack, e_reuse}, 0);
    issue(2);
    chk("R2 free after 2", free_id, 4);
  endtask

  task automatic t_noack();
    do_reset();
    req = 1; req_id = 5; @(negedge clk);
    req_id = 6; @(negedge clk);
    req = 0;
    chk("R3 noack flag", e_noack, 1);
    chk("R3 id6 not recorded", busy, 8'b0010_0000);
    ack = 1; @(negedge clk); ack = 0;
    req = 1; req_id = 7; ack = 0; @(negedge clk); req = 0;
    chk("R3 accepted after ack", busy, 8'b1010_0000);
    // back-to-back with same-cycle ack is legal
    do_reset();
    req = 1; req_id = 1; @(negedge clk);
    req_id = 2; ack = 1; @(negedge clk);
    req = 0; @(negedge clk); ack = 0;
    chk("R3 same-cycle ack", {busy, e_noack}, {8'b0000_0110, 1'b0});
  endtask

  task automatic t_reuse();
    do_reset();
    issue(4); issue(4);
    errs("R4 reuse only", 4'b0100);
    chk("R4 busy kept", busy, 8'b0001_0000);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < NID; i++) issue(i);
    chk("R2 full", {busy, full}, {8'hFF, 1'b1});
    issue(3);
    errs("R5 over not reuse", 4'b0010);
  endtask

  task automatic t_return();
    do_reset();
    issue(4); issue(2);
    for (int c = 0; c < BEATS - 1; c++) beat(4, c);
    chk("R6 busy after 3 beats", busy, 8'b0001_0100);
    beat(4, 3);
    chk("R6 retired on 4th", busy, 8'b0000_0100);
    chk("R6 free", free_id, 0);
    for (int c = 0; c < BEATS; c++) beat(2, c);
    chk("R6 second return retired", busy, 0);
    errs("R6 no errors", 4'b0000);
  endtask

  task automatic t_delay();
    do_reset();
    issue(5);
    rvld = 1; rid = 5; rchunk = 2;
    @(negedge clk);
    rvld = 0; rid = 0; rchunk = 0;
    @(negedge clk);
    chk("R8 not early", {bvld, bdata}, 0);
    rdata = 128'hDEAD_BEEF_0123; recc = 28'hABC1234;
    @(negedge clk);
    chk("R8 strobe on time", {bvld, bid, bchunk}, {1'b1, 3'd5, 2'd2});
    chk("R8 data passed", {bdata, becc}, {128'hDEAD_BEEF_0123, 28'hABC1234});
    @(negedge clk);
    chk("R8 gone after", {bvld, bid, bchunk, bdata, becc}, 0);
    rdata = '0; recc = '0;
  endtask

  task automatic t_unexp();
    do_reset();
    issue(1);
    beat(6, 0);
    errs("R7 unexpected", 4'b1000);
    chk("R7 busy untouched", busy, 8'b0000_0010);
    repeat (5) @(negedge clk);
    issue(2);
    for (int c = 1; c < BEATS; c++) beat(1, c);
    errs("R9 sticky", 4'b1000);
    do_reset();
    errs("R9 cleared by reset", 4'b0000);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_issue();
    t_noack();
    t_reuse();
    t_full();
    t_return();
    t_delay();
    t_unexp();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule